// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered record of the register renames made by an out-of-order core's rename stage, so that the core can recover precisely. Each rename inserts entries into a circular history. An entry holds the instruction's sequence number, the architectural register, the physical register just allocated, the physical register that was mapped before, and a placeholder flag. An instruction that writes no register still inserts one placeholder entry, so that every renamed instruction is present in the history. An instruction with several destinations inserts one entry per destination in a single cycle, in destination order, and all of them carry its sequence number.

On a squash to sequence S, the block walks back from the newest entry and handles one entry per cycle. For each real entry newer than S it writes the old physical register back into the external map table and pushes the new physical register onto the external free list. On a commit of sequence C, it retires entries from the oldest end, also one per cycle, through the last entry whose sequence is C or older, and pushes each real entry's previous physical register onto the free list. `busy` is high while a walk runs. Sequence numbers are compared as plain unsigned values, so the issuer must keep them increasing and free of wrap while entries are live.

Top module: `rn_hist_buf`

## Requirements
- R1: After reset `busy`, `map_we` and `fl_push` are low and `ins_ready` is high for any destination count up to MAX_DST.
- R2: An accepted insert with `ins_ndst` = n > 0 stores n entries, where destination k is taken from field k (bits k*W upward) of the packed operand buses, all tagged `ins_seq`. With n = 0 it stores one placeholder entry. A squash returns the entries of one instruction in reverse destination order.
- R3: `ins_ready` is high exactly when no walk is running, `sq_valid` and `cm_valid` are both low, and the free slots number at least max(1, `ins_ndst`).
- R4: A squash removes, newest first and one per cycle, every entry whose sequence is greater than `sq_seq`. For a real entry, `map_we` and `fl_push` are high in the same cycle, with `map_areg` set to its architectural register, `map_preg` to its previous physical register and `fl_preg` to its new physical register. A placeholder drives neither strobe.
- R5: A squash request while the history is empty has no effect: `busy` stays low and no strobe is driven.
- R6: A commit removes, oldest first and one per cycle, every entry whose sequence is at most `cm_seq`. For a real entry `fl_push` is high with `fl_preg` set to its previous physical register. A commit never drives `map_we`.
- R7: A commit request is ignored, with `busy` staying low and no push made, when the history is empty or its oldest entry has a sequence greater than `cm_seq`.
- R8: When `sq_valid` and `cm_valid` are both high while idle, the squash runs, and commit requests made during a squash walk are dropped.
- R9: A walk that removes k entries holds `busy` high for exactly k+1 cycles, starting in the cycle after the accepted request. The last of these cycles drives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request for one renamed instruction |
| ins_ready | output | 1 | Insert can be accepted this cycle |
| ins_seq | input | SEQ_W | Sequence number of the instruction |
| ins_ndst | input | $clog2(MAX_DST+1) | Number of destinations, 0 for a placeholder |
| ins_areg | input | MAX_DST*AREG_W | Packed architectural destinations, field k = destination k |
| ins_pnew | input | MAX_DST*PREG_W | Packed newly allocated physical registers |
| ins_pold | input | MAX_DST*PREG_W | Packed previously mapped physical registers |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; newer entries are undone |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Committed sequence number |
| busy | output | 1 | A squash or commit walk is in progress |
| map_we | output | 1 | Map table restore strobe |
| map_areg | output | AREG_W | Architectural register to restore |
| map_preg | output | PREG_W | Physical register restored into the map |
| fl_push | output | 1 | Free list push strobe |
| fl_preg | output | PREG_W | Physical register returned to the free list |

## Verification
The hardest situation to reach is a full history whose last instruction spans several destinations while the free space is just under what the next instruction needs. In that state the refusal in R3 depends on the exact count. The bench reaches it by filling the history with destination counts that rotate through 0, 1 and 2, using a different phase in each round, so that the last slots are requested by each kind of instruction in turn. It also holds a commit request across an entire squash walk, which shows the drop in R8 at the ports as the absence of any free-list push once `busy` falls.

// File: rtl/rn_hist_buf.sv
module rn_hist_buf #(
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 8,
  parameter int AREG_W  = 5,
  parameter int PREG_W  = 6,
  parameter int MAX_DST = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_valid,
  output logic                      ins_ready,
  input  logic [SEQ_W-1:0]          ins_seq,
  input  logic [$clog2(MAX_DST+1)-1:0] ins_ndst,
  input  logic [MAX_DST*AREG_W-1:0] ins_areg,
  input  logic [MAX_DST*PREG_W-1:0] ins_pnew,
  input  logic [MAX_DST*PREG_W-1:0] ins_pold,
  input  logic                      sq_valid,
  input  logic [SEQ_W-1:0]          sq_seq,
  input  logic                      cm_valid,
  input  logic [SEQ_W-1:0]          cm_seq,
  output logic                      busy,
  output logic                      map_we,
  output logic [AREG_W-1:0]         map_areg,
  output logic [PREG_W-1:0]         map_preg,
  output logic                      fl_push,
  output logic [PREG_W-1:0]         fl_preg
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(MAX_DST+1);
  localparam logic [1:0] M_IDLE = 2'd0, M_SQ = 2'd1, M_CM = 2'd2;

  logic [SEQ_W-1:0]  seq_m  [DEPTH];
  logic [AREG_W-1:0] areg_m [DEPTH];
  logic [PREG_W-1:0] pnew_m [DEPTH];
  logic [PREG_W-1:0] pold_m [DEPTH];
  logic              ph_m   [DEPTH];

  logic [AW:0]      head_q, tail_q;
  logic [1:0]       mode_q;
  logic [SEQ_W-1:0] lim_q;

  logic [AW:0]   used_w, free_w, need_w;
  logic [AW-1:0] new_i, old_i;
  logic          empty_w, sq_hit, cm_hit, sq_go, cm_go, ins_fire;

  assign used_w  = tail_q - head_q;
  assign free_w  = (AW+1)'(DEPTH) - used_w;
  assign need_w  = (ins_ndst == NW'(0)) ? (AW+1)'(1) : (AW+1)'(ins_ndst);
  assign empty_w = (used_w == '0);
  assign new_i   = tail_q[AW-1:0] - AW'(1);
  assign old_i   = head_q[AW-1:0];

  assign sq_hit = (mode_q == M_SQ) && !empty_w && (seq_m[new_i] > lim_q);
  assign cm_hit = (mode_q == M_CM) && !empty_w && (seq_m[old_i] <= lim_q);
  assign sq_go  = (mode_q == M_IDLE) && sq_valid && !empty_w;
  assign cm_go  = (mode_q == M_IDLE) && !sq_valid && cm_valid && !empty_w &&
                  (seq_m[old_i] <= cm_seq);

  assign ins_ready = (mode_q == M_IDLE) && !sq_valid && !cm_valid && (free_w >= need_w);
  assign ins_fire  = ins_valid && ins_ready;

  assign busy     = (mode_q != M_IDLE);
  assign map_we   = sq_hit && !ph_m[new_i];
  assign map_areg = areg_m[new_i];
  assign map_preg = pold_m[new_i];
  assign fl_push  = (sq_hit && !ph_m[new_i]) || (cm_hit && !ph_m[old_i]);
  assign fl_preg  = (mode_q == M_SQ) ? pnew_m[new_i] : pold_m[old_i];

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_DST; k++) begin
      if (ins_fire && (k < int'(need_w))) begin
        seq_m [tail_q[AW-1:0] + AW'(k)] <= ins_seq;
        areg_m[tail_q[AW-1:0] + AW'(k)] <= ins_areg[k*AREG_W +: AREG_W];
        pnew_m[tail_q[AW-1:0] + AW'(k)] <= ins_pnew[k*PREG_W +: PREG_W];
        pold_m[tail_q[AW-1:0] + AW'(k)] <= ins_pold[k*PREG_W +: PREG_W];
        ph_m  [tail_q[AW-1:0] + AW'(k)] <= (ins_ndst == NW'(0));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      mode_q <= M_IDLE;
      lim_q  <= '0;
    end else begin
      if (ins_fire)    tail_q <= tail_q + need_w;
      else if (sq_hit) tail_q <= tail_q - (AW+1)'(1);
      if (cm_hit)      head_q <= head_q + (AW+1)'(1);
      case (mode_q)
        M_IDLE: begin
          if (sq_go) begin
            mode_q <= M_SQ;
            lim_q  <= sq_seq;
          end else if (cm_go) begin
            mode_q <= M_CM;
            lim_q  <= cm_seq;
          end
        end
        M_SQ:    if (!sq_hit) mode_q <= M_IDLE;
        M_CM:    if (!cm_hit) mode_q <= M_IDLE;
        default: mode_q <= M_IDLE;
      endcase
    end
  end
endmodule

module rn_hist_buf_chk #(
  parameter int PREG_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ins_ready,
  input logic              sq_valid,
  input logic              cm_valid,
  input logic              map_we,
  input logic              fl_push,
  input logic [PREG_W-1:0] map_preg,
  input logic [PREG_W-1:0] fl_preg
);
  p_restore_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> fl_push);

  p_strobe_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_push |-> busy);

  p_no_insert_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);

  p_walk_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sq_valid || cm_valid));

  p_squash_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sq_valid && cm_valid) |=> !(fl_push && !map_we));

  p_known_preg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> (!$isunknown(map_preg) && !$isunknown(fl_preg)));
endmodule

bind rn_hist_buf rn_hist_buf_chk #(.PREG_W(PREG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ins_ready(ins_ready),
  .sq_valid(sq_valid), .cm_valid(cm_valid), .map_we(map_we),
  .fl_push(fl_push), .map_preg(map_preg), .fl_preg(fl_preg)
);

// File: tb/rn_hist_buf_tb_top.sv
`timescale 1ns/1ps
module rn_hist_buf_tb_top;
  localparam int DEPTH = 8, SEQ_W = 8, AREG_W = 5, PREG_W = 6, MAX_DST = 2;
  localparam int NW = $clog2(MAX_DST+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, sq_valid = 1'b0, cm_valid = 1'b0;
  logic ins_ready, busy, map_we, fl_push;
  logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0, cm_seq = '0;
  logic [NW-1:0] ins_ndst = '0;
  logic [MAX_DST*AREG_W-1:0] ins_areg = '0;
  logic [MAX_DST*PREG_W-1:0] ins_pnew = '0, ins_pold = '0;
  logic [AREG_W-1:0] map_areg;
  logic [PREG_W-1:0] map_preg, fl_preg;

  always #2 clk = ~clk;

  rn_hist_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
                .MAX_DST(MAX_DST)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_seq(ins_seq), .ins_ndst(ins_ndst), .ins_areg(ins_areg),
    .ins_pnew(ins_pnew), .ins_pold(ins_pold), .sq_valid(sq_valid),
    .sq_seq(sq_seq), .cm_valid(cm_valid), .cm_seq(cm_seq), .busy(busy),
    .map_we(map_we), .map_areg(map_areg), .map_preg(map_preg),
    .fl_push(fl_push), .fl_preg(fl_preg));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int q_seq[$], q_areg[$], q_pnew[$], q_pold[$], q_ph[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  function automatic int f_areg(int s, int k); return (s*7 + k) % 32; endfunction
  function automatic int f_pnew(int s, int k); return (s*5 + k*3 + 1) % 64; endfunction
  function automatic int f_pold(int s, int k); return (s*11 + k + 2) % 64; endfunction

  task automatic do_insert(input int s, input int nd);
    int need = (nd == 0) ? 1 : nd;
    bit exp_rdy = (DEPTH - q_seq.size()) >= need;
    ins_seq = SEQ_W'(s); ins_ndst = NW'(nd);
    for (int k = 0; k < MAX_DST; k++) begin
      ins_areg[k*AREG_W +: AREG_W] = AREG_W'(f_areg(s, k));
      ins_pnew[k*PREG_W +: PREG_W] = PREG_W'(f_pnew(s, k));
      ins_pold[k*PREG_W +: PREG_W] = PREG_W'(f_pold(s, k));
    end
    ins_valid = 1'b1;
    #0;
    chk(ins_ready == exp_rdy, "R3 ready vs free space", int'(ins_ready), int'(exp_rdy));
    step();
    ins_valid = 1'b0;
    if (exp_rdy) begin
      for (int k = 0; k < need; k++) begin
        q_seq.push_back(s);
        q_areg.push_back(f_areg(s, k));
        q_pnew.push_back(f_pnew(s, k));
        q_pold.push_back(f_pold(s, k));
        q_ph.push_back(nd == 0);
      end
    end
  endtask

  task automatic do_squash(input int s, input bit with_cm);
    bit was_empty = (q_seq.size() == 0);
    sq_valid = 1'b1; sq_seq = SEQ_W'(s);
    cm_valid = with_cm; cm_seq = '1;
    step();
    sq_valid = 1'b0;
    if (was_empty) begin
      chk(!busy, "R5 empty squash busy", int'(busy), 0);
      chk(!map_we && !fl_push, "R5 empty squash strobes", int'(fl_push), 0);
      cm_valid = 1'b0;
      step();
      chk(!busy, "R5 empty squash stays idle", int'(busy), 0);
      return;
    end
    while (q_seq.size() > 0 && q_seq[$] > s) begin
      chk(busy, "R9 busy during squash", int'(busy), 1);
      chk(!ins_ready, "R3 ready low while busy", int'(ins_ready), 0);
      chk(map_we == !q_ph[$], "R4 map_we", int'(map_we), int'(!q_ph[$]));
      chk(fl_push == !q_ph[$], "R4 fl_push", int'(fl_push), int'(!q_ph[$]));
      if (!q_ph[$]) begin
        chk(int'(map_areg) == q_areg[$], "R2 R4 restored arch reg", int'(map_areg), q_areg[$]);
        chk(int'(map_preg) == q_pold[$], "R4 restored phys reg", int'(map_preg), q_pold[$]);
        chk(int'(fl_preg) == q_pnew[$], "R4 freed new reg", int'(fl_preg), q_pnew[$]);
      end
      void'(q_seq.pop_back()); void'(q_areg.pop_back()); void'(q_pnew.pop_back());
      void'(q_pold.pop_back()); void'(q_ph.pop_back());
      step();
    end
    chk(busy, "R9 final squash cycle busy", int'(busy), 1);
    chk(!fl_push && !map_we, "R9 final squash cycle quiet", int'(fl_push), 0);
    cm_valid = 1'b0;
    step();
    chk(!busy, "R9 squash done", int'(busy), 0);
    chk(!fl_push, "R8 held commit dropped", int'(fl_push), 0);
  endtask

  task automatic do_commit(input int c);
    bit ign = (q_seq.size() == 0) || (q_seq[0] > c);
    cm_valid = 1'b1; cm_seq = SEQ_W'(c);
    step();
    cm_valid = 1'b0;
    if (ign) begin
      chk(!busy, "R7 ignored commit busy", int'(busy), 0);
      chk(!fl_push, "R7 ignored commit push", int'(fl_push), 0);
      return;
    end
    while (q_seq.size() > 0 && q_seq[0] <= c) begin
      chk(busy, "R9 busy during commit", int'(busy), 1);
      chk(!map_we, "R6 commit never restores", int'(map_we), 0);
      chk(fl_push == !q_ph[0], "R6 fl_push", int'(fl_push), int'(!q_ph[0]));
      if (!q_ph[0])
        chk(int'(fl_preg) == q_pold[0], "R6 freed old reg", int'(fl_preg), q_pold[0]);
      void'(q_seq.pop_front()); void'(q_areg.pop_front()); void'(q_pnew.pop_front());
      void'(q_pold.pop_front()); void'(q_ph.pop_front());
      step();
    end
    chk(busy, "R9 final commit cycle busy", int'(busy), 1);
    chk(!fl_push, "R9 final commit cycle quiet", int'(fl_push), 0);
    step();
    chk(!busy, "R9 commit done", int'(busy), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!busy, "R1 reset busy", int'(busy), 0);
    chk(!map_we && !fl_push, "R1 reset strobes", int'(fl_push), 0);
    for (int nd = 0; nd <= MAX_DST; nd++) begin
      ins_ndst = NW'(nd); #0;
      chk(ins_ready, "R1 reset ready", int'(ins_ready), 1);
    end
    ins_ndst = '0;
    do_squash(9, 1'b0);
    do_commit(9);
    for (int r = 0; r < 12; r++) begin
      s = 1;
      for (int i = 0; i < 9; i++) begin
        do_insert(s, (r + i) % 3);
        s++;
      end
      do_commit(0);
      do_commit(1 + (r % 3));
      do_insert(s, MAX_DST); s++;
      do_insert(s, 0); s++;
      do_squash(s - 1 - (r % 4), r[0]);
      do_commit(q_seq.size() > 0 ? q_seq[0] : 0);
      do_squash(0, 1'b0);
      do_squash(0, 1'b0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule